// File: doc/BRIEF.md
# Golay Training Field Generator

This block produces the bipolar short training field of a millimetre-wave OFDM preamble, one chip per accepted transfer. The field is built from a length-128 complementary Golay pair. It consists of fifteen back-to-back copies of the first sequence, and the last of those copies has its sign flipped. No chip is stored. Each chip is derived from its index within the copy, either by a parity rule or by unrolling the pair recursion. The recursion starts from a Kronecker delta for both members. At each order the first member is the old first member followed by the old second member. The new second member is the old first member followed by the negated old second member.

A single start pulse launches a field. The chips leave on a valid/ready stream. A transfer happens on a rising clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the generator holds the current chip and flags and does not advance. `out_valid` never depends on `out_ready`. The partner sequence of the pair travels alongside on a second data bit, framed the same way. A separate combinational lookup port returns both members of the pair for any index, so a correlator can fetch reference chips without disturbing the stream.

Top module: `golay_stf_gen`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low until a start pulse is accepted.
- R2: A `start` pulse while idle raises `out_valid` on the next cycle, presenting chip 0 of copy 0.
- R3: Chips are encoded as 1 for +1 and 0 for −1. The first-member chip at 7-bit index i is 0 exactly when i has an odd number of positions j (0..5) with bits j and j+1 both set.
- R4: The partner chip equals the first-member chip, inverted whenever bit 6 of the index is set.
- R5: A field is 15 copies of 128 chips (1920 transfers) with indices running 0..127 in each copy. Copies 0..13 carry the sequences as in R3/R4. On copy 14, both `out_chip_a` and `out_chip_b` are inverted.
- R6: `out_last` is high only while transfer number 1919 (counting from 0) is offered. After that transfer, `out_valid` is low on the next cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_chip_a`, `out_chip_b` and `out_last` hold their values and the field position does not advance.
- R8: A `start` pulse received while a field is in progress is ignored. The field neither restarts nor changes length. This includes a pulse in the same cycle as the final transfer.
- R9: `ref_a` and `ref_b` give the first-member and partner chips of `ref_idx` combinationally by the rules of R3 and R4, with no framing inversion. They are independent of the stream state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to launch a field when idle |
| out_ready | input | 1 | Downstream accepts the offered chip |
| out_valid | output | 1 | A chip is offered |
| out_chip_a | output | 1 | Training-field chip (1 = +1, 0 = −1) |
| out_chip_b | output | 1 | Partner-sequence chip, same framing |
| out_last | output | 1 | Offered chip is the final one of the field |
| ref_idx | input | 7 | Reference lookup index |
| ref_a | output | 1 | First-member reference chip at `ref_idx` |
| ref_b | output | 1 | Partner reference chip at `ref_idx` |

## Verification
The assertions assume that `start` and `out_ready` are known, two-valued levels sampled on the clock edge, and that the consumer may hold `out_ready` low for any length of time. The stall-hold property only relies on `out_ready` being honoured by the source, not on it being stable. The stimulus changes both inputs only on falling edges. It runs one field with `out_ready` held high and a stray start mid-field, and a second field with a repeating stall pattern and a start in the final-transfer cycle, so every offered chip is checked against a position counted only on real transfers.

// File: rtl/golay_pkg.sv
package golay_pkg;
  typedef enum logic {
    GEN_IDLE = 1'b0,
    GEN_RUN  = 1'b1
  } gen_state_t;
endpackage

// File: rtl/golay_chip.sv
module golay_chip #(
  parameter int ORDER       = 7,
  parameter bit CLOSED_FORM = 1'b1
) (
  input  logic [ORDER-1:0] idx,
  output logic             chip_a,
  output logic             chip_b
);
  generate
    if (CLOSED_FORM) begin : g_parity
      // Parity of adjacent set-bit pairs decides the sign of the first member.
      logic [ORDER-2:0] pairs;
      assign pairs  = idx[ORDER-2:0] & idx[ORDER-1:1];
      assign chip_a = ~(^pairs);
      assign chip_b = chip_a ^ idx[ORDER-1];
    end else begin : g_recur
      // Unrolled pair recursion, one stage per index bit, LSB first.
      logic ra, rb, na, nb;
      always_comb begin
        ra = 1'b1;
        rb = 1'b1;
        for (int k = 0; k < ORDER; k++) begin
          if (idx[k]) begin
            na = rb;
            nb = ~rb;
          end else begin
            na = ra;
            nb = ra;
          end
          ra = na;
          rb = nb;
        end
      end
      assign chip_a = ra;
      assign chip_b = rb;
    end
  endgenerate
endmodule

// File: rtl/golay_seq.sv
module golay_seq
  import golay_pkg::*;
#(
  parameter int ORDER  = 7,
  parameter int COPIES = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ready,
  output logic             valid,
  output logic             last,
  output logic             final_copy,
  output logic [ORDER-1:0] chip_idx
);
  localparam int CW = (COPIES > 1) ? $clog2(COPIES) : 1;
  localparam logic [CW-1:0]    REP_END = CW'(COPIES - 1);
  localparam logic [ORDER-1:0] IDX_END = '1;

  gen_state_t      state_q;
  logic [CW-1:0]   rep_q;
  logic [ORDER-1:0] idx_q;

  assign valid      = (state_q == GEN_RUN);
  assign final_copy = (rep_q == REP_END);
  assign last       = valid && final_copy && (idx_q == IDX_END);
  assign chip_idx   = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= GEN_IDLE;
      rep_q   <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        GEN_IDLE: begin
          if (start) begin
            state_q <= GEN_RUN;
            rep_q   <= '0;
            idx_q   <= '0;
          end
        end
        default: begin
          if (ready) begin
            if (last) begin
              state_q <= GEN_IDLE;
            end else begin
              idx_q <= idx_q + ORDER'(1);
              if (idx_q == IDX_END) rep_q <= rep_q + CW'(1);
            end
          end
        end
      endcase
    end
  end

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && start) |=> (valid && chip_idx == '0 && !final_copy));

  assert_end_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && last) |=> !valid);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && start && !ready) |=> (valid && $stable(chip_idx) && $stable(rep_q)));

  assert_rep_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (rep_q <= REP_END));
endmodule

// File: rtl/golay_stf_gen.sv
module golay_stf_gen #(
  parameter int ORDER       = 7,
  parameter int COPIES      = 15,
  parameter bit CLOSED_FORM = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_chip_a,
  output logic             out_chip_b,
  output logic             out_last,
  input  logic [ORDER-1:0] ref_idx,
  output logic             ref_a,
  output logic             ref_b
);
  logic             final_copy;
  logic [ORDER-1:0] chip_idx;
  logic             seq_a, seq_b;

  golay_seq #(.ORDER(ORDER), .COPIES(COPIES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(out_ready),
    .valid(out_valid), .last(out_last), .final_copy(final_copy),
    .chip_idx(chip_idx)
  );

  golay_chip #(.ORDER(ORDER), .CLOSED_FORM(CLOSED_FORM)) u_stream_chip (
    .idx(chip_idx), .chip_a(seq_a), .chip_b(seq_b)
  );

  golay_chip #(.ORDER(ORDER), .CLOSED_FORM(CLOSED_FORM)) u_ref_chip (
    .idx(ref_idx), .chip_a(ref_a), .chip_b(ref_b)
  );

  // Negated final copy: one XOR on each data bit.
  assign out_chip_a = seq_a ^ final_copy;
  assign out_chip_b = seq_b ^ final_copy;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_chip_a) && $stable(out_chip_b) && $stable(out_last)));

  assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

// File: tb/sim_golay_stf_gen.sv
module sim_golay_stf_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid, out_chip_a, out_chip_b, out_last;
  logic [6:0] ref_idx = '0;
  logic       ref_a, ref_b;

  int  vectors = 0;
  int  errors  = 0;
  bit  done    = 1'b0;

  always #10 clk = ~clk;

  golay_stf_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .out_ready(out_ready),
    .out_valid(out_valid), .out_chip_a(out_chip_a), .out_chip_b(out_chip_b),
    .out_last(out_last), .ref_idx(ref_idx), .ref_a(ref_a), .ref_b(ref_b)
  );

  // Expected pair by running the recursion on index bits, LSB first.
  function automatic void golay_ref(input int idx, output int a, output int b);
    int ta;
    a = 1;
    b = 1;
    for (int k = 0; k < 7; k++) begin
      if ((idx >> k) & 1) begin
        ta = b;
        b  = -b;
      end else begin
        ta = a;
        b  = a;
      end
      a = ta;
    end
  endfunction

  function automatic logic enc(input int v);
    return (v > 0) ? 1'b1 : 1'b0;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // mode 0: ready always high, stray start mid-field.
  // mode 1: stall pattern, start on the final-transfer cycle.
  task automatic run_field(input int mode);
    int pos = 0;
    int cyc = 0;
    int ea, eb;
    logic sgn;
    @(negedge clk);
    start = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check("R2 valid after start", out_valid, 1'b1);
    while (pos < 1920 && cyc < 20000) begin
      out_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      start = 1'b0;
      if (mode == 0 && pos == 700) start = 1'b1;
      if (mode == 1 && pos == 1919) start = 1'b1;
      check("R5 valid during field", out_valid, 1'b1);
      golay_ref(pos % 128, ea, eb);
      sgn = (pos >= 1792);
      check("R3/R5 chip a", out_chip_a, enc(ea) ^ sgn);
      check("R4/R5 chip b", out_chip_b, enc(eb) ^ sgn);
      check("R6 last flag", out_last, (pos == 1919));
      if (out_ready) pos++;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    out_ready = 1'b0;
    check("R6/R8 idle after field", out_valid, 1'b0);
    check("R6 last low after field", out_last, 1'b0);
    repeat (3) @(negedge clk);
    check("R8 no restart", out_valid, 1'b0);
  endtask

  initial begin
    int ea, eb;
    repeat (3) @(negedge clk);
    check("R1 valid at reset", out_valid, 1'b0);
    check("R1 last at reset", out_last, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", out_valid, 1'b0);
    // R9: reference port sweep over all indices.
    for (int i = 0; i < 128; i++) begin
      ref_idx = 7'(i);
      #1;
      golay_ref(i, ea, eb);
      check("R9/R3 ref_a", ref_a, enc(ea));
      check("R9/R4 ref_b", ref_b, enc(eb));
    end
    run_field(0);
    run_field(1);
    // R9: reference port unaffected by a running stream.
    @(negedge clk);
    start = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ref_idx = 7'd77;
    #1;
    golay_ref(77, ea, eb);
    check("R9 ref during stream", ref_a, enc(ea));
    check("R9 ref_b during stream", ref_b, enc(eb));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule